// File: doc/BRIEF.md
# RMS and Power Computation Engine

This block turns a stream of signed voltage and current samples into four metering results: RMS voltage, RMS current, mean (active) power and apparent power. An internal pacing divider produces the sample strobe from the master clock. The strobe fires once every K times 2^PRE_LOG clocks, which is 1024 clocks with the default settings. On each strobe the block captures both sample inputs and scales each one by its own channel gain. It then accumulates the two squares and the voltage-current product.

After N samples the window closes. The three sums are divided by N in parallel serial dividers. The two mean squares then pass through a digit-by-digit square root, and apparent power is formed as the product of the two roots. All four outputs update together in the cycle where a one-cycle completion pulse is raised. N and K are inputs, but the block latches them only at a window boundary, so a value written in the middle of a window applies from the next window. Samples and results are two's-complement fractions of full scale, Q1.15 with the default width.

Top module: `rmsp_engine`

## Requirements
- R1: `sample_stb` is high for one cycle every K·2^PRE_LOG clocks. The first pulse comes 2^PRE_LOG−1 rising edges after reset is released, with K=1.
- R2: A window spans N strobes, and `done` stays low until its last strobe has been taken. Values of `n_len` and `k_div` are sampled only on a window's last strobe and govern the next window. After reset the block uses N=N_RST and K=K_RST (4000 and 1 by default).
- R3: An `n_len` or `k_div` of zero is taken as one.
- R4: Each sample is multiplied by its unsigned gain, which has 2 integer bits and GW−2 fraction bits (64 = 1.0 with the default GW=8). The product is shifted arithmetically right by GW−2 (floor) and clamped to the range −32768..32767.
- R5: `v_rms` is floor(sqrt(floor(Σv²/N))), where v is the scaled sample taken as a Q1.15 integer. The result is clamped to 32767. `i_rms` is formed the same way from the current samples.
- R6: `p_act` has the sign of Σv·i and magnitude min(floor(floor(|Σv·i|/N)/2^15), 32767).
- R7: `s_app` equals floor(v_rms·i_rms/2^15), using the values published in the same cycle.
- R8: After reset all results and `done` are zero. `done` is a one-cycle pulse, and the four results change only in the cycle `done` is high.
- R9: `done` rises within 2·DW+NW+DW+6 clocks (70 by default) of the rising edge that takes a window's last sample. This is shorter than one sample period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| v_smp | input | DW | Voltage sample, signed fraction |
| i_smp | input | DW | Current sample, signed fraction |
| v_gain | input | GW | Voltage channel gain, unsigned with 2 integer bits |
| i_gain | input | GW | Current channel gain, unsigned with 2 integer bits |
| k_div | input | KW | Sample pacing divider for the next window |
| n_len | input | NW | Samples per window for the next window |
| sample_stb | output | 1 | Pulse marking the clock edge where samples are taken |
| v_rms | output | DW | RMS voltage, non-negative fraction |
| i_rms | output | DW | RMS current, non-negative fraction |
| p_act | output | DW | Active power, signed fraction |
| s_app | output | DW | Apparent power, non-negative fraction |
| done | output | 1 | One-cycle pulse when all four results update |

## Verification
The bench builds the block with PRE_LOG=7 and N_RST=3, and keeps the default widths. A 128-clock sample period and a three-sample first window put the reset configuration, deferred N and K changes, zero-to-one substitution and many random windows within a short run. A sample period of 128 clocks is still longer than the 70-clock result latency, so the bench can also confirm that results are ready before the next window needs the arithmetic.

// File: rtl/rmsp_pkg.sv
package rmsp_pkg;
   localparam int CH_V    = 0;
   localparam int CH_I    = 1;
   localparam int CH_P    = 2;
   localparam int N_ROOTS = 2;
   localparam int N_MEANS = 3;
endpackage

// File: rtl/rmsp_pacer.sv
module rmsp_pacer #(
   parameter int PRE_LOG = 10,
   parameter int KW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [KW-1:0] k_div,
   output logic          stb
);
   logic [PRE_LOG-1:0] pre;
   logic [KW-1:0]      kc;
   logic               k_end;

   assign k_end = (kc == k_div - KW'(1));
   assign stb   = (&pre) && k_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre <= '0;
         kc  <= '0;
      end else begin
         pre <= pre + PRE_LOG'(1);
         if (&pre) kc <= k_end ? '0 : kc + KW'(1);
      end
   end
endmodule

// File: rtl/rmsp_gain.sv
module rmsp_gain #(
   parameter int DW = 16,
   parameter int GW = 8
) (
   input  logic signed [DW-1:0] x,
   input  logic        [GW-1:0] g,
   output logic signed [DW-1:0] y
);
   localparam int PW = DW + GW + 1;
   localparam int FB = GW - 2;
   localparam logic signed [PW-1:0] HI = PW'((1 <<< (DW-1)) - 1);
   localparam logic signed [PW-1:0] LO = ~HI;

   logic signed [PW-1:0] prod, shv;

   assign prod = PW'(x) * PW'($signed({1'b0, g}));

   generate
      if (FB == 0) begin : g_int_gain
         assign shv = prod;
      end else begin : g_frac_gain
         assign shv = prod >>> FB;
      end
   endgenerate

   always_comb begin
      if (shv > HI)      y = HI[DW-1:0];
      else if (shv < LO) y = LO[DW-1:0];
      else               y = shv[DW-1:0];
   end
endmodule

// File: rtl/rmsp_div.sv
module rmsp_div #(
   parameter int NUM_W = 48,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo,
   output logic             done
);
   localparam int CW = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem;
   logic [CW-1:0]    cnt;
   logic             busy;
   logic [DEN_W:0]   trial;
   logic             take;

   assign trial = {rem, quo[NUM_W-1]};
   assign take  = (trial >= {1'b0, den});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo  <= '0;
         rem  <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            quo  <= num;
            rem  <= '0;
            cnt  <= CW'(NUM_W);
            busy <= 1'b1;
         end else if (busy) begin
            quo <= {quo[NUM_W-2:0], take};
            rem <= take ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rmsp_sqrt.sv
module rmsp_sqrt #(
   parameter int RW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [2*RW-1:0] rad,
   output logic [RW-1:0]   root,
   output logic            done
);
   localparam int CW  = $clog2(RW + 1);
   localparam int RMW = RW + 2;

   logic [2*RW-1:0] sh;
   logic [RMW-1:0]  rem;
   logic [CW-1:0]   cnt;
   logic            busy;
   logic [RW+3:0]   rt, tr;
   logic            take;

   assign rt   = {rem, sh[2*RW-1 -: 2]};
   assign tr   = {2'b00, root, 2'b01};
   assign take = (rt >= tr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         rem  <= '0;
         root <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            sh   <= rad;
            rem  <= '0;
            root <= '0;
            cnt  <= CW'(RW);
            busy <= 1'b1;
         end else if (busy) begin
            sh   <= sh << 2;
            rem  <= take ? RMW'(rt - tr) : rt[RMW-1:0];
            root <= {root[RW-2:0], take};
            cnt  <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rmsp_engine.sv
module rmsp_engine
   import rmsp_pkg::*;
#(
   parameter int DW      = 16,
   parameter int GW      = 8,
   parameter int KW      = 8,
   parameter int NW      = 16,
   parameter int PRE_LOG = 10,
   parameter int N_RST   = 4000,
   parameter int K_RST   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [DW-1:0] v_smp,
   input  logic signed [DW-1:0] i_smp,
   input  logic        [GW-1:0] v_gain,
   input  logic        [GW-1:0] i_gain,
   input  logic        [KW-1:0] k_div,
   input  logic        [NW-1:0] n_len,
   output logic                 sample_stb,
   output logic        [DW-1:0] v_rms,
   output logic        [DW-1:0] i_rms,
   output logic signed [DW-1:0] p_act,
   output logic        [DW-1:0] s_app,
   output logic                 done
);
   localparam int PW    = 2 * DW;
   localparam int ACC_W = PW + NW;
   localparam int FB    = DW - 1;
   localparam int LAT   = ACC_W + DW + 6;
   localparam logic [DW-1:0] FS_MAX = {1'b0, {(DW-1){1'b1}}};

   generate
      if (DW < 4 || DW > 30) begin : g_bad_dw
         $error("rmsp_engine: DW must lie in 4..30");
      end
      if (GW < 2) begin : g_bad_gw
         $error("rmsp_engine: GW must be at least 2");
      end
      if (NW < 1 || NW > 30 || KW < 1 || KW > 30) begin : g_bad_cfg_w
         $error("rmsp_engine: NW and KW must lie in 1..30");
      end
      if ((1 << PRE_LOG) <= LAT) begin : g_bad_pre
         $error("rmsp_engine: sample period shorter than result latency");
      end
      if (N_RST < 1 || K_RST < 1 || N_RST >= (1 << NW) || K_RST >= (1 << KW)) begin : g_bad_rst
         $error("rmsp_engine: reset N or K out of range");
      end
   endgenerate

   // window configuration, latched only at a window boundary
   logic [NW-1:0] cur_n, n_cnt, den;
   logic [KW-1:0] cur_k;
   logic          last_smp, go, p_neg;

   rmsp_pacer #(.PRE_LOG(PRE_LOG), .KW(KW)) u_pace (
      .clk(clk), .rst_n(rst_n), .k_div(cur_k), .stb(sample_stb));

   assign last_smp = sample_stb && (n_cnt == cur_n - NW'(1));

   // per-channel gain stage
   logic signed [DW-1:0] raw [N_ROOTS];
   logic        [GW-1:0] gn  [N_ROOTS];
   logic signed [DW-1:0] sc  [N_ROOTS];

   assign raw[CH_V] = v_smp;
   assign raw[CH_I] = i_smp;
   assign gn[CH_V]  = v_gain;
   assign gn[CH_I]  = i_gain;

   generate
      for (genvar c = 0; c < N_ROOTS; c++) begin : g_scale
         rmsp_gain #(.DW(DW), .GW(GW)) u_gain (.x(raw[c]), .g(gn[c]), .y(sc[c]));
      end
   endgenerate

   // squares, instantaneous power and running sums
   logic signed [PW-1:0]    sq_v, sq_i, pin;
   logic        [ACC_W-1:0] acc_v, acc_i, nx_v, nx_i, nx_pm;
   logic signed [ACC_W-1:0] acc_p, nx_p;
   logic        [ACC_W-1:0] num [N_MEANS];

   assign sq_v  = PW'(sc[CH_V]) * PW'(sc[CH_V]);
   assign sq_i  = PW'(sc[CH_I]) * PW'(sc[CH_I]);
   assign pin   = PW'(sc[CH_V]) * PW'(sc[CH_I]);
   assign nx_v  = acc_v + {{NW{1'b0}}, sq_v};
   assign nx_i  = acc_i + {{NW{1'b0}}, sq_i};
   assign nx_p  = acc_p + $signed({{NW{pin[PW-1]}}, pin});
   assign nx_pm = nx_p[ACC_W-1] ? ACC_W'(-nx_p) : ACC_W'(nx_p);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_n <= NW'(N_RST);
         cur_k <= KW'(K_RST);
         n_cnt <= '0;
         den   <= NW'(1);
         acc_v <= '0;
         acc_i <= '0;
         acc_p <= '0;
         for (int c = 0; c < N_MEANS; c++) num[c] <= '0;
         p_neg <= 1'b0;
         go    <= 1'b0;
      end else begin
         go <= 1'b0;
         if (sample_stb) begin
            if (last_smp) begin
               num[CH_V] <= nx_v;
               num[CH_I] <= nx_i;
               num[CH_P] <= nx_pm;
               p_neg     <= nx_p[ACC_W-1];
               den       <= cur_n;
               go        <= 1'b1;
               acc_v     <= '0;
               acc_i     <= '0;
               acc_p     <= '0;
               n_cnt     <= '0;
               cur_n     <= (n_len == '0) ? NW'(1) : n_len;
               cur_k     <= (k_div == '0) ? KW'(1) : k_div;
            end else begin
               acc_v <= nx_v;
               acc_i <= nx_i;
               acc_p <= nx_p;
               n_cnt <= n_cnt + NW'(1);
            end
         end
      end
   end

   // divide by N, three channels in parallel
   logic [ACC_W-1:0]   quo [N_MEANS];
   logic [N_MEANS-1:0] dv_done;
   logic               mean_rdy;

   generate
      for (genvar c = 0; c < N_MEANS; c++) begin : g_div
         rmsp_div #(.NUM_W(ACC_W), .DEN_W(NW)) u_div (
            .clk(clk), .rst_n(rst_n), .start(go), .num(num[c]), .den(den),
            .quo(quo[c]), .done(dv_done[c]));
      end
   endgenerate

   assign mean_rdy = &dv_done;

   // square roots of the mean squares
   logic [PW-1:0]      rad      [N_ROOTS];
   logic [DW-1:0]      root     [N_ROOTS];
   logic [DW-1:0]      root_sat [N_ROOTS];
   logic [N_ROOTS-1:0] rt_done;
   logic               rt_fin;

   generate
      for (genvar c = 0; c < N_ROOTS; c++) begin : g_root
         assign rad[c] = (quo[c] > ACC_W'({PW{1'b1}})) ? {PW{1'b1}} : quo[c][PW-1:0];
         rmsp_sqrt #(.RW(DW)) u_sqrt (
            .clk(clk), .rst_n(rst_n), .start(mean_rdy), .rad(rad[c]),
            .root(root[c]), .done(rt_done[c]));
         assign root_sat[c] = (root[c] > FS_MAX) ? FS_MAX : root[c];
      end
   endgenerate

   assign rt_fin = &rt_done;

   // active power magnitude and sign, apparent power
   logic [ACC_W-1:0]     pm_sh;
   logic [DW-1:0]        p_mag, s_calc;
   logic signed [DW-1:0] p_hold;
   logic [PW-1:0]        vi, vi_sh;

   assign pm_sh  = quo[CH_P] >> FB;
   assign p_mag  = (pm_sh > ACC_W'(FS_MAX)) ? FS_MAX : pm_sh[DW-1:0];
   assign vi     = PW'(root_sat[CH_V]) * PW'(root_sat[CH_I]);
   assign vi_sh  = vi >> FB;
   assign s_calc = (vi_sh > PW'(FS_MAX)) ? FS_MAX : vi_sh[DW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_hold <= '0;
         v_rms  <= '0;
         i_rms  <= '0;
         p_act  <= '0;
         s_app  <= '0;
         done   <= 1'b0;
      end else begin
         if (mean_rdy) p_hold <= p_neg ? -$signed(p_mag) : $signed(p_mag);
         done <= rt_fin;
         if (rt_fin) begin
            v_rms <= root_sat[CH_V];
            i_rms <= root_sat[CH_I];
            p_act <= p_hold;
            s_app <= s_calc;
         end
      end
   end
endmodule

// File: rtl/rmsp_engine_chk.sv
module rmsp_engine_chk #(
   parameter int DW      = 16,
   parameter int PRE_LOG = 10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sample_stb,
   input logic        [DW-1:0] v_rms,
   input logic        [DW-1:0] i_rms,
   input logic signed [DW-1:0] p_act,
   input logic        [DW-1:0] s_app,
   input logic                 done
);
   logic [31:0] gap;
   logic        seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (sample_stb) begin
         gap  <= '0;
         seen <= 1'b1;
      end else if (gap != '1) begin
         gap <= gap + 32'd1;
      end
   end

   AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && seen) |-> (gap >= 32'((1 << PRE_LOG) - 1))); // R1

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(v_rms) && $stable(i_rms) && $stable(p_act) && $stable(s_app))); // R8

   AST_RMS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!v_rms[DW-1] && !i_rms[DW-1])); // R5

   AST_PACT_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (p_act != {1'b1, {(DW-1){1'b0}}})); // R6

   AST_APP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((s_app <= v_rms) && (s_app <= i_rms))); // R7
endmodule

bind rmsp_engine rmsp_engine_chk #(.DW(DW), .PRE_LOG(PRE_LOG)) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .v_rms(v_rms),
   .i_rms(i_rms), .p_act(p_act), .s_app(s_app), .done(done));

// File: tb/rmsp_engine_test.sv
`timescale 1ns/1ps
module rmsp_engine_test;
   localparam int DW = 16, GW = 8, KW = 8, NW = 16, PRE_LOG = 7;
   localparam int N_RST = 3, K_RST = 1;
   localparam int PER = 1 << PRE_LOG;
   localparam int LAT = 2*DW + NW + DW + 6;
   localparam longint FSM = (longint'(1) << (DW-1)) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [DW-1:0] v_smp = '0, i_smp = '0;
   logic [GW-1:0] v_gain = 8'd64, i_gain = 8'd64;
   logic [KW-1:0] k_div = KW'(K_RST);
   logic [NW-1:0] n_len = NW'(N_RST);
   logic sample_stb, done;
   logic [DW-1:0] v_rms, i_rms, s_app;
   logic signed [DW-1:0] p_act;

   int n_chk = 0, n_fail = 0;
   bit finished = 0, first_seen = 0;
   longint cyc = 0, rel_cyc = 0, last_stb = 0;
   int m_n = N_RST, m_k = K_RST;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rmsp_engine #(.DW(DW), .GW(GW), .KW(KW), .NW(NW), .PRE_LOG(PRE_LOG),
                 .N_RST(N_RST), .K_RST(K_RST)) uut (
      .clk(clk), .rst_n(rst_n), .v_smp(v_smp), .i_smp(i_smp),
      .v_gain(v_gain), .i_gain(i_gain), .k_div(k_div), .n_len(n_len),
      .sample_stb(sample_stb), .v_rms(v_rms), .i_rms(i_rms),
      .p_act(p_act), .s_app(s_app), .done(done));

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint scale(longint x, longint g);
      longint p = (x * g) >>> (GW - 2);
      if (p > FSM) p = FSM;
      if (p < -FSM - 1) p = -FSM - 1;
      return p;
   endfunction

   function automatic longint isqrt(longint x);
      longint r = 0;
      for (int b = DW; b >= 0; b--) begin
         longint t = r + (longint'(1) << b);
         if (t * t <= x) r = t;
      end
      return r;
   endfunction

   task automatic drive_pair(int mode);
      int a;
      a = $signed(16'($urandom));
      case (mode)
         1: begin v_smp = 16'sh8000; i_smp = 16'sh8000; end
         2: begin v_smp = '0; i_smp = '0; end
         3: begin v_smp = 16'(a); i_smp = 16'(-(a / 2)); end
         default: begin v_smp = 16'($urandom); i_smp = 16'($urandom); end
      endcase
   endtask

   task automatic run_window(string tag, int mode, int wr_n, int wr_k,
                             logic [GW-1:0] gv, logic [GW-1:0] gi);
      longint sv = 0, si = 0, sp = 0, sx, sy, ev, ei, ep, es, mag;
      int nxt_n = 1, nxt_k = 1, gap;
      v_gain = gv;
      i_gain = gi;
      drive_pair(mode);
      for (int s = 0; s < m_n; s++) begin
         do begin
            @(negedge clk);
            if (done) check({tag, " R2 done before last sample"}, 1, 0);
         end while (!sample_stb);
         if (!first_seen) begin
            check("R1 first strobe delay", cyc - rel_cyc, PER - 1);
            first_seen = 1;
         end else begin
            check({tag, " R1 strobe spacing"}, cyc - last_stb, m_k * PER);
         end
         last_stb = cyc;
         sx = scale(longint'(v_smp), longint'(v_gain));
         sy = scale(longint'(i_smp), longint'(i_gain));
         sv += sx * sx;
         si += sy * sy;
         sp += sx * sy;
         if (s == m_n - 1) begin
            nxt_n = (n_len == 0) ? 1 : int'(n_len);
            nxt_k = (k_div == 0) ? 1 : int'(k_div);
         end
         @(posedge clk);
         #1;
         if (s == 0 && wr_n >= 0) begin
            n_len = NW'(wr_n);
            k_div = KW'(wr_k);
         end
         drive_pair(mode);
      end
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (!done && gap < LAT + 5);
      check({tag, " R9 latency bound"}, longint'(gap <= LAT && done), 1);
      ev = isqrt(sv / m_n); if (ev > FSM) ev = FSM;
      ei = isqrt(si / m_n); if (ei > FSM) ei = FSM;
      mag = ((sp < 0 ? -sp : sp) / m_n) >> (DW - 1);
      if (mag > FSM) mag = FSM;
      ep = (sp < 0) ? -mag : mag;
      es = (ev * ei) >> (DW - 1);
      check({tag, " R5 v_rms"}, longint'(v_rms), ev);
      check({tag, " R5 i_rms"}, longint'(i_rms), ei);
      check({tag, " R6 p_act"}, longint'(p_act), ep);
      check({tag, " R7 s_app"}, longint'(s_app), es);
      @(negedge clk);
      check({tag, " R8 done single cycle"}, longint'(done), 0);
      check({tag, " R8 result held"}, longint'(v_rms), ev);
      m_n = nxt_n;
      m_k = nxt_k;
   endtask

   task automatic summary();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog R9 actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      repeat (4) @(negedge clk);
      check("R8 reset v_rms", longint'(v_rms), 0);
      check("R8 reset i_rms", longint'(i_rms), 0);
      check("R8 reset p_act", longint'(p_act), 0);
      check("R8 reset s_app", longint'(s_app), 0);
      check("R8 reset done", longint'(done), 0);
      check("R1 reset strobe", longint'(sample_stb), 0);
      rst_n = 1'b1;
      rel_cyc = cyc;
      // default window N=3 K=1; write N=5 K=2 mid-window
      run_window("R2 reset default window", 0, 5, 2, 8'd64, 8'd64);
      // N=5 K=2 now in force; write zeros mid-window
      run_window("R2 deferred N K window", 0, 0, 0, 8'd96, 8'd40);
      // zeros taken as one
      run_window("R3 zero config window", 0, 2, 1, 8'd200, 8'd17);
      run_window("R3 zero config repeat", 3, -1, 0, 8'd64, 8'd64);
      // full negative scale with maximum gain saturates everywhere
      run_window("R4 saturation window", 1, 4, 1, 8'd255, 8'd255);
      run_window("R5 zero samples window", 2, -1, 0, 8'd64, 8'd64);
      run_window("R4 fractional gain window", 0, -1, 0, 8'd33, 8'd161);
      for (int w = 0; w < 10; w++) begin
         run_window((w % 2) ? "R6 negative power window" : "R7 random window",
                    (w % 2) ? 3 : 0, 1 + int'($urandom % 6), 1 + int'($urandom % 2),
                    GW'($urandom), GW'($urandom));
      end
      summary();
      $finish;
   end
endmodule